// File: doc/BRIEF.md
# Random Value Request Port

This block is the shared front end through which several requesters draw random material. It holds two queues of 64-bit words: one filled by a deterministic generator (plain random values) and one filled by the entropy conditioner (seed values). Both producers sit outside the block and appear only as write ports. Each requester raises a request line. With it the requester gives a kind bit, which chooses the random queue or the seed queue, and a two-bit width code. The port replies on a shared response bus with a one-hot strobe, a success flag and the data.

A single round-robin arbiter covers every requester, and a pacing counter lets the port accept at most one transaction in each window of eight clocks. A request that finds its queue empty still counts as a transaction. It returns a cleared flag and all-zero data, so callers must test the flag and never the value. Seed requests read the conditioner queue directly and fail whenever demand outruns supply.

Top module: `rvp_port`

## Requirements
- R1: The width code sets how much of the word is returned: code 0 gives bits 15:0, code 1 gives bits 31:0, and codes 2 and 3 give all 64 bits. Bits above the selected width read as zero.
- R2: `rsp_ok` is 1 on a response exactly when the selected queue held a word at the accepting edge.
- R3: A failed response carries `rsp_ok` = 0 and `rsp_data` = 0.
- R4: Two accepted transactions are always at least 8 clocks apart, across all requesters. Under continuous demand they are exactly 8 clocks apart.
- R5: A request with kind bit 1 reads only the seed queue and fails when that queue is empty, even if the random queue holds data. The random queue is left untouched.
- R6: Each successful transaction removes exactly one 64-bit word, whatever its width code, and words leave in the order they were written.
- R7: After a grant to requester i, the next grant goes to the first requesting index after i, counted cyclically.
- R8: When all requesters request continuously, each one receives an equal number of grants over any span of 2·NREQ grants.
- R9: The strobe bit `rsp_valid[i]` of the granted requester is high for exactly one cycle, in the cycle that follows the accepting clock edge. At most one strobe bit is high at a time.
- R10: After reset no strobe is high, `rsp_ok` is 0 and both queues are empty.
- R11: Each queue holds DEPTH words. `*_full` rises when the queue holds DEPTH words, and a write while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rnd_push | input | 1 | Write strobe for the random-value queue |
| rnd_push_data | input | 64 | Word written to the random-value queue |
| rnd_full | output | 1 | Random-value queue is full |
| seed_push | input | 1 | Write strobe for the seed queue |
| seed_push_data | input | 64 | Word written to the seed queue |
| seed_full | output | 1 | Seed queue is full |
| req_valid | input | NREQ | Per-requester request line, held until served |
| req_seed | input | NREQ | Per-requester kind: 1 selects the seed queue |
| req_width | input | 2·NREQ | Per-requester width code, requester i at bits 2i+1:2i |
| rsp_valid | output | NREQ | One-hot response strobe |
| rsp_ok | output | 1 | Success flag of the current response |
| rsp_data | output | 64 | Response data, zero on failure |

## Verification
When the pacer is idle, a request raised before a clock edge is accepted at that edge. Its strobe, flag and data are registered at the same edge and are sampled on the falling edge that follows, so the response is due one cycle after the stimulus. Each single-request scenario first waits more than eight idle cycles so that the one-cycle latency can be asserted exactly. In the saturation scenario the bench stamps every strobe with a cycle count and expects stamps exactly 8 apart. A queue write lands at the rising edge between two falling edges of the bench, so it is visible to any request raised afterwards.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
   localparam int RVP_DW = 64;

   typedef enum logic [1:0] {
      WSEL_16  = 2'd0,
      WSEL_32  = 2'd1,
      WSEL_64  = 2'd2,
      WSEL_64B = 2'd3
   } rvp_wsel_e;

   function automatic logic [RVP_DW-1:0] rvp_keep(input logic [1:0] code);
      case (rvp_wsel_e'(code))
         WSEL_16: rvp_keep = {{(RVP_DW-16){1'b0}}, {16{1'b1}}};
         WSEL_32: rvp_keep = {{(RVP_DW-32){1'b0}}, {32{1'b1}}};
         default: rvp_keep = {RVP_DW{1'b1}};
      endcase
   endfunction
endpackage

// File: rtl/rvp_fifo.sv
module rvp_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rvp_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);
   a_r6_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/rvp_rr_arb.sv
module rvp_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         adv,
   output logic [N-1:0] gnt,
   output logic         any
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("rvp_rr_arb: N must be at least 2");
   end

   logic [PW-1:0] ptr;
   logic [PW-1:0] win;
   int            idx;
   logic          found;

   always_comb begin
      gnt   = '0;
      win   = '0;
      found = 1'b0;
      idx   = 0;
      for (int i = 0; i < N; i++) begin
         idx = int'(ptr) + i;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            gnt[idx] = 1'b1;
            win      = PW'(idx);
            found    = 1'b1;
         end
      end
   end

   assign any = found;

   always_ff @(posedge clk) begin
      if (!rst_n)             ptr <= '0;
      else if (adv && found)  ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
   end

   a_r7_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   a_r7_gnt_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/rvp_pacer.sv
module rvp_pacer #(
   parameter int GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   output logic ready
);
   localparam int CW = $clog2(GAP + 1);

   if (GAP < 1) begin : g_bad_gap
      $error("rvp_pacer: GAP must be at least 1");
   end

   logic [CW-1:0] cnt;

   assign ready = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt <= '0;
      else if (take && ready)   cnt <= CW'(GAP - 1);
      else if (cnt != '0)       cnt <= cnt - 1'b1;
   end

   a_r4_take_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ready) |=> (cnt == CW'(GAP - 1)));
endmodule

// File: rtl/rvp_port.sv
module rvp_port
   import rvp_pkg::*;
#(
   parameter int NREQ  = 4,
   parameter int DEPTH = 8,
   parameter int GAP   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rnd_push,
   input  logic [63:0]         rnd_push_data,
   output logic                rnd_full,
   input  logic                seed_push,
   input  logic [63:0]         seed_push_data,
   output logic                seed_full,
   input  logic [NREQ-1:0]     req_valid,
   input  logic [NREQ-1:0]     req_seed,
   input  logic [2*NREQ-1:0]   req_width,
   output logic [NREQ-1:0]     rsp_valid,
   output logic                rsp_ok,
   output logic [63:0]         rsp_data
);
   localparam int GW = $clog2(GAP + 1);

   logic [NREQ-1:0] gnt;
   logic            any_req, slot_free, accept;
   logic            sel_seed, avail;
   logic [1:0]      sel_w;
   logic [63:0]     rnd_head, seed_head, head;
   logic            rnd_empty, seed_empty;
   logic            rnd_pop, seed_pop;

   rvp_rr_arb #(.N(NREQ)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_valid), .adv(accept),
      .gnt(gnt), .any(any_req)
   );

   rvp_pacer #(.GAP(GAP)) u_pace (
      .clk(clk), .rst_n(rst_n), .take(any_req), .ready(slot_free)
   );

   assign accept = slot_free && any_req;

   always_comb begin
      sel_seed = 1'b0;
      sel_w    = 2'b00;
      for (int i = 0; i < NREQ; i++) begin
         if (gnt[i]) begin
            sel_seed = req_seed[i];
            sel_w    = req_width[2*i +: 2];
         end
      end
   end

   assign avail    = sel_seed ? !seed_empty : !rnd_empty;
   assign head     = sel_seed ? seed_head : rnd_head;
   assign rnd_pop  = accept && !sel_seed;
   assign seed_pop = accept && sel_seed;

   rvp_fifo #(.W(RVP_DW), .DEPTH(DEPTH)) u_rnd_q (
      .clk(clk), .rst_n(rst_n), .push(rnd_push), .push_data(rnd_push_data),
      .pop(rnd_pop), .head(rnd_head), .empty(rnd_empty), .full(rnd_full)
   );

   rvp_fifo #(.W(RVP_DW), .DEPTH(DEPTH)) u_seed_q (
      .clk(clk), .rst_n(rst_n), .push(seed_push), .push_data(seed_push_data),
      .pop(seed_pop), .head(seed_head), .empty(seed_empty), .full(seed_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_ok    <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= accept ? gnt : '0;
         rsp_ok    <= accept && avail;
         rsp_data  <= (accept && avail) ? (head & rvp_keep(sel_w)) : '0;
      end
   end

   logic [GW-1:0] since_rsp;
   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rsp <= GW'(GAP);
      else if (rsp_valid != '0)   since_rsp <= GW'(1);
      else if (since_rsp < GW'(GAP)) since_rsp <= since_rsp + 1'b1;
   end

   a_r9_rsp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid));
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid != '0) |=> (rsp_valid == '0));
   a_r4_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid != '0) |-> (since_rsp >= GW'(GAP)));
   a_r3_zero_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      ((rsp_valid != '0) && !rsp_ok) |-> (rsp_data == '0));
   a_r2_ok_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ok |-> (rsp_valid != '0));
endmodule

// File: tb/test_rvp_port.sv
`timescale 1ns/1ps
module test_rvp_port;
   localparam int N = 4;
   localparam int D = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rnd_push = 1'b0, seed_push = 1'b0;
   logic [63:0]   rnd_push_data = '0, seed_push_data = '0;
   logic          rnd_full, seed_full;
   logic [N-1:0]  req_valid = '0, req_seed = '0;
   logic [2*N-1:0] req_width = '0;
   logic [N-1:0]  rsp_valid;
   logic          rsp_ok;
   logic [63:0]   rsp_data;

   int runs = 0, fails = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   rvp_port #(.NREQ(N), .DEPTH(D), .GAP(8)) i_rvp_port (
      .clk(clk), .rst_n(rst_n),
      .rnd_push(rnd_push), .rnd_push_data(rnd_push_data), .rnd_full(rnd_full),
      .seed_push(seed_push), .seed_push_data(seed_push_data), .seed_full(seed_full),
      .req_valid(req_valid), .req_seed(req_seed), .req_width(req_width),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data)
   );

   task automatic check(input bit cond, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      runs++;
      if (!cond) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_rnd(input logic [63:0] d);
      @(negedge clk);
      rnd_push = 1'b1; rnd_push_data = d;
      @(negedge clk);
      rnd_push = 1'b0;
   endtask

   task automatic push_seed(input logic [63:0] d);
      @(negedge clk);
      seed_push = 1'b1; seed_push_data = d;
      @(negedge clk);
      seed_push = 1'b0;
   endtask

   // raise one request, wait for its strobe, drop it
   task automatic single(input int i, input bit seed, input logic [1:0] w,
                         output bit ok, output logic [63:0] data, output int lat);
      @(negedge clk);
      req_valid[i] = 1'b1; req_seed[i] = seed; req_width[2*i +: 2] = w;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!rsp_valid[i] && lat < 40);
      ok = rsp_ok; data = rsp_data;
      req_valid[i] = 1'b0;
   endtask

   task automatic t_reset;
      check(rsp_valid == '0, "R10 strobe after reset", 64'(rsp_valid), 0);
      check(rsp_ok == 1'b0, "R10 ok after reset", 64'(rsp_ok), 0);
      check(!rnd_full && !seed_full, "R10 queues empty", 64'({rnd_full, seed_full}), 0);
   endtask

   task automatic t_empty;
      bit ok; logic [63:0] d; int lat;
      idle(10);
      single(0, 1'b0, 2'd2, ok, d, lat);
      check(lat == 1, "R9 latency one cycle", 64'(lat), 1);
      check(ok == 1'b0, "R2 flag low on empty", 64'(ok), 0);
      check(d == '0, "R3 zero data on fail", d, 0);
      @(negedge clk);
      check(rsp_valid == '0, "R9 strobe single cycle", 64'(rsp_valid), 0);
   endtask

   task automatic t_width;
      bit ok; logic [63:0] d; int lat;
      push_rnd(64'hA1A2_A3A4_A5A6_A7A8);
      push_rnd(64'hB1B2_B3B4_B5B6_B7B8);
      push_rnd(64'hC1C2_C3C4_C5C6_C7C8);
      push_rnd(64'hD1D2_D3D4_D5D6_D7D8);
      idle(10);
      single(1, 1'b0, 2'd0, ok, d, lat);
      check(ok && d == 64'h0000_0000_0000_A7A8, "R1 width 16", d, 64'hA7A8);
      single(2, 1'b0, 2'd1, ok, d, lat);
      check(ok && d == 64'h0000_0000_B5B6_B7B8, "R6 next word after 16-bit read", d, 64'hB5B6_B7B8);
      single(3, 1'b0, 2'd2, ok, d, lat);
      check(ok && d == 64'hC1C2_C3C4_C5C6_C7C8, "R1 width 64", d, 64'hC1C2_C3C4_C5C6_C7C8);
      single(0, 1'b0, 2'd3, ok, d, lat);
      check(ok && d == 64'hD1D2_D3D4_D5D6_D7D8, "R1 code 3 full width", d, 64'hD1D2_D3D4_D5D6_D7D8);
      single(1, 1'b0, 2'd2, ok, d, lat);
      check(!ok && d == '0, "R6 queue drained after four reads", d, 0);
   endtask

   task automatic t_seed;
      bit ok; logic [63:0] d; int lat;
      push_rnd(64'h1111_2222_3333_4444);
      single(0, 1'b1, 2'd2, ok, d, lat);
      check(!ok && d == '0, "R5 seed fails on empty seed queue", d, 0);
      push_seed(64'h5EED_0000_CAFE_F00D);
      single(1, 1'b1, 2'd2, ok, d, lat);
      check(ok && d == 64'h5EED_0000_CAFE_F00D, "R5 seed word", d, 64'h5EED_0000_CAFE_F00D);
      single(2, 1'b0, 2'd2, ok, d, lat);
      check(ok && d == 64'h1111_2222_3333_4444, "R5 random queue untouched", d, 64'h1111_2222_3333_4444);
   endtask

   task automatic t_saturate;
      int who[8]; int when[8]; int got = 0; int share[N];
      for (int i = 0; i < N; i++) share[i] = 0;
      idle(10);
      @(negedge clk);
      req_valid = '1; req_seed = '0; req_width = '1;
      while (got < 8 && cyc < 100000) begin
         @(negedge clk);
         if (rsp_valid != '0) begin
            check($countones(rsp_valid) == 1, "R9 one strobe bit", 64'(rsp_valid), 1);
            for (int i = 0; i < N; i++) if (rsp_valid[i]) who[got] = i;
            when[got] = cyc;
            got++;
         end
      end
      req_valid = '0;
      for (int k = 1; k < 8; k++) begin
         check(when[k] - when[k-1] == 8, "R4 spacing under load", 64'(when[k] - when[k-1]), 8);
         check(who[k] == (who[k-1] + 1) % N, "R7 rotation", 64'(who[k]), 64'((who[k-1] + 1) % N));
      end
      for (int k = 0; k < 8; k++) share[who[k]]++;
      for (int i = 0; i < N; i++)
         check(share[i] == 2, "R8 equal share", 64'(share[i]), 2);
   endtask

   task automatic t_sparse;
      int prev = -1; int got = 0;
      idle(10);
      @(negedge clk);
      req_valid = 4'b1010; req_width = '1;
      while (got < 4 && cyc < 100000) begin
         @(negedge clk);
         if (rsp_valid != '0) begin
            int cur = rsp_valid[1] ? 1 : 3;
            if (prev >= 0)
               check(cur != prev, "R7 skips idle requesters", 64'(cur), 64'(prev == 1 ? 3 : 1));
            prev = cur; got++;
         end
      end
      req_valid = '0;
   endtask

   task automatic t_full;
      bit ok; logic [63:0] d; int lat;
      for (int k = 0; k < D; k++) push_rnd(64'(k + 100));
      check(rnd_full == 1'b1, "R11 full at depth", 64'(rnd_full), 1);
      push_rnd(64'hDEAD);
      for (int k = 0; k < D; k++) begin
         single(k % N, 1'b0, 2'd2, ok, d, lat);
         check(ok && d == 64'(k + 100), "R11 order kept at depth", d, 64'(k + 100));
      end
      single(0, 1'b0, 2'd2, ok, d, lat);
      check(!ok && d == '0, "R11 write while full dropped", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_empty;
      t_width;
      t_seed;
      t_saturate;
      t_sparse;
      t_full;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

   initial begin
      #500000;
      runs++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end
endmodule